// File: doc/BRIEF.md
# General-Purpose I/O Expander Port Register File

This block is the register and pin-control core of an eight-line general-purpose I/O expander. A host-side controller (for example a serial bus slave sitting next to it) presents a two-bit register select, write data and single-cycle write and read strobes. The block keeps a direction register, an output-value register, a read-inversion register and a captured-input register. From these it produces per-line drive values and drive enables for the pads.

Line 0 is built as an open-drain line. It never drives high: its enable is raised only when the line is set as an output holding a 0. Every other line is push-pull.

Pin outputs are registered, so a write becomes visible on the pads one cycle after it lands in its register. The input register samples the sampled pad levels, with the inversion mask applied, at the read strobe. It then holds that value steady while a byte is being shifted out.

Top module: `ioexp_portfile`

## Requirements
- R1: After reset the output register reads 0x00, the inversion register 0xF0, the direction register 0xFF and the captured-input register 0x00; all drive values and drive enables are 0.
- R2: Select code 0 reads the captured-input register, 1 the output register, 2 the inversion register and 3 the direction register; read data follows the select in the same cycle with no clock edge.
- R3: A direction bit of 1 makes that line an input: its drive enable and drive value are 0. A direction bit of 0 on a push-pull line gives enable 1 and drive equal to the output-register bit.
- R4: A write strobe with select code 0 changes no register.
- R5: A read strobe with select code 0 captures, at that clock edge, the pad levels XOR the inversion register. This applies whatever each line's direction, and the captured value holds until the next such strobe.
- R6: Reading select code 1 returns the stored output bits whatever the pad levels. Output bits on lines set as inputs do not reach the pads.
- R7: Line 0 is open-drain: its drive value is always 0 and its enable is 1 only when its direction bit is 0 and its output bit is 0.
- R8: A write strobe updates the selected register at that clock edge, so it can be read back in the next cycle. The pad outputs reflect it one clock edge later.
- R9: While the active-low reset is low, all registers and pad outputs hold their defaults, even when write and read strobes are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select code |
| wr_data | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe, one cycle |
| rd_stb | input | 1 | Read strobe, one cycle |
| pad_in | input | 8 | Sampled pad levels |
| rd_data | output | 8 | Read data for the selected register |
| pad_drv | output | 8 | Per-line drive value |
| pad_oe | output | 8 | Per-line drive enable |

## Verification
On every cycle the assertions check four things. Input-configured lines never drive. Line 0 never drives high and enables only while holding a 0. A write to code 0 leaves the other registers untouched, and an output write lands one edge later. While reset is low, every register sits at its default. The exact drive pattern for every direction and output combination can only be shown by the bench's sweeps. The same holds for inversion of captured inputs across all masks, the hold of the captured value between strobes, and the same-cycle read-select behaviour.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;

    typedef enum logic [1:0] {
        SEL_INPUT    = 2'd0,
        SEL_OUTPUT   = 2'd1,
        SEL_POLARITY = 2'd2,
        SEL_CONFIG   = 2'd3
    } regsel_e;

    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/ioexp_regbank.sv
module ioexp_regbank
    import ioexp_pkg::*;
#(
    parameter int unsigned    W       = 8,
    parameter logic [W-1:0]   OUT_RST = '0,
    parameter logic [W-1:0]   POL_RST = '0,
    parameter logic [W-1:0]   CFG_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [W-1:0]     pad_i,
    output logic [W-1:0]     out_o,
    output logic [W-1:0]     pol_o,
    output logic [W-1:0]     cfg_o,
    output logic [W-1:0]     inp_o
);

    typedef struct packed {
        logic [W-1:0] outr;
        logic [W-1:0] pol;
        logic [W-1:0] cfg;
        logic [W-1:0] inp;
    } bank_t;

    localparam bank_t BANK_RST = '{outr: OUT_RST, pol: POL_RST, cfg: CFG_RST, inp: '0};

    bank_t   bank_d, bank_q;
    regsel_e sel_e;

    assign sel_e = regsel_e'(sel_i);

    always_comb begin
        bank_d = bank_q;
        if (wr_i) begin
            case (sel_e)
                SEL_OUTPUT:   bank_d.outr = wdata_i;
                SEL_POLARITY: bank_d.pol  = wdata_i;
                SEL_CONFIG:   bank_d.cfg  = wdata_i;
                default:      bank_d.outr = bank_q.outr;
            endcase
        end
        if (rd_i && (sel_e == SEL_INPUT)) begin
            bank_d.inp = pad_i ^ bank_q.pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= BANK_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign out_o = bank_q.outr;
    assign pol_o = bank_q.pol;
    assign cfg_o = bank_q.cfg;
    assign inp_o = bank_q.inp;

    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_INPUT) |=> ($stable(out_o) && $stable(pol_o) && $stable(cfg_o))); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_OUTPUT) |=> (out_o == $past(wdata_i))); // R8

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_DEFAULTS: assert (out_o == OUT_RST && pol_o == POL_RST
                                        && cfg_o == CFG_RST && inp_o == '0); // R9
        end
    end

endmodule

// File: rtl/ioexp_pindrv.sv
module ioexp_pindrv #(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] OD_MASK = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] out_i,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] drv_o,
    output logic [W-1:0] oe_o
);

    typedef struct packed {
        logic [W-1:0] drv;
        logic [W-1:0] oe;
    } pins_t;

    pins_t        pins_d, pins_q;
    logic [W-1:0] bit_drv, bit_oe;

    for (genvar i = 0; i < W; i++) begin : g_line
        if (OD_MASK[i]) begin : g_od
            assign bit_oe[i]  = ~cfg_i[i] & ~out_i[i];
            assign bit_drv[i] = 1'b0;
        end else begin : g_pp
            assign bit_oe[i]  = ~cfg_i[i];
            assign bit_drv[i] = ~cfg_i[i] & out_i[i];
        end
    end

    always_comb begin
        pins_d     = pins_q;
        pins_d.oe  = bit_oe;
        pins_d.drv = bit_drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign drv_o = pins_q.drv;
    assign oe_o  = pins_q.oe;

    AST_INPUT_LINE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (((oe_o | drv_o) & $past(cfg_i)) == '0)); // R3

    AST_OPEN_DRAIN_SINKS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (((drv_o & OD_MASK) == '0) && ((oe_o & OD_MASK & $past(out_i)) == '0))); // R7

endmodule

// File: rtl/ioexp_rdmux.sv
module ioexp_rdmux
    import ioexp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     inp_i,
    input  logic [W-1:0]     out_i,
    input  logic [W-1:0]     pol_i,
    input  logic [W-1:0]     cfg_i,
    output logic [W-1:0]     rdata_o
);

    always_comb begin
        case (regsel_e'(sel_i))
            SEL_INPUT:    rdata_o = inp_i;
            SEL_OUTPUT:   rdata_o = out_i;
            SEL_POLARITY: rdata_o = pol_i;
            default:      rdata_o = cfg_i;
        endcase
    end

endmodule

// File: rtl/ioexp_portfile.sv
module ioexp_portfile
    import ioexp_pkg::*;
#(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] OUT_RST = 8'h00,
    parameter logic [W-1:0] POL_RST = 8'hF0,
    parameter logic [W-1:0] CFG_RST = 8'hFF,
    parameter logic [W-1:0] OD_MASK = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     pad_drv,
    output logic [W-1:0]     pad_oe
);

    logic [W-1:0] out_q, pol_q, cfg_q, inp_q;

    ioexp_regbank #(
        .W       (W),
        .OUT_RST (OUT_RST),
        .POL_RST (POL_RST),
        .CFG_RST (CFG_RST)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (reg_sel),
        .wdata_i (wr_data),
        .wr_i    (wr_stb),
        .rd_i    (rd_stb),
        .pad_i   (pad_in),
        .out_o   (out_q),
        .pol_o   (pol_q),
        .cfg_o   (cfg_q),
        .inp_o   (inp_q)
    );

    ioexp_pindrv #(
        .W       (W),
        .OD_MASK (OD_MASK)
    ) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .out_i (out_q),
        .cfg_i (cfg_q),
        .drv_o (pad_drv),
        .oe_o  (pad_oe)
    );

    ioexp_rdmux #(
        .W (W)
    ) u_rd (
        .sel_i   (reg_sel),
        .inp_i   (inp_q),
        .out_i   (out_q),
        .pol_i   (pol_q),
        .cfg_i   (cfg_q),
        .rdata_o (rd_data)
    );

endmodule

// File: tb/ioexp_portfile_test.sv
module ioexp_portfile_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] rd_data, pad_drv, pad_oe;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ioexp_portfile uut (
        .clk (clk), .rst_n (rst_n), .reg_sel (reg_sel), .wr_data (wr_data),
        .wr_stb (wr_stb), .rd_stb (rd_stb), .pad_in (pad_in),
        .rd_data (rd_data), .pad_drv (pad_drv), .pad_oe (pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic capture();
        @(negedge clk);
        reg_sel = 2'd0; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = rd_data;
    endtask

    function automatic logic [7:0] exp_oe(input logic [7:0] cfg, input logic [7:0] outv);
        return (~cfg & 8'hFE) | {7'd0, ~cfg[0] & ~outv[0]};
    endfunction

    function automatic logic [7:0] exp_drv(input logic [7:0] cfg, input logic [7:0] outv);
        return ~cfg & outv & 8'hFE;
    endfunction

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        #25;
        // R1 and R9: defaults while reset is low, strobes ignored
        @(negedge clk);
        reg_sel = 2'd3; wr_data = 8'h00; wr_stb = 1'b1; rd_stb = 1'b1; pad_in = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        peek(2'd0, v); chk("R9 inp in reset", v, 8'h00);
        peek(2'd1, v); chk("R9 out in reset", v, 8'h00);
        peek(2'd2, v); chk("R9 pol in reset", v, 8'hF0);
        peek(2'd3, v); chk("R9 cfg in reset", v, 8'hFF);
        chk("R9 oe in reset", pad_oe, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: defaults after release
        peek(2'd0, v); chk("R1 inp default", v, 8'h00);
        peek(2'd1, v); chk("R1 out default", v, 8'h00);
        peek(2'd2, v); chk("R1 pol default", v, 8'hF0);
        peek(2'd3, v); chk("R1 cfg default", v, 8'hFF);
        chk("R1 drv default", pad_drv, 8'h00);
        chk("R1 oe default", pad_oe, 8'h00);

        // R8: pads follow one edge after the register
        wr(2'd1, 8'hA5);
        wr(2'd3, 8'h00);
        peek(2'd3, v); chk("R8 cfg readback", v, 8'h00);
        chk("R8 oe not yet", pad_oe, 8'h00);
        @(negedge clk);
        chk("R8 oe next edge", pad_oe, exp_oe(8'h00, 8'hA5));
        chk("R8 drv next edge", pad_drv, exp_drv(8'h00, 8'hA5));

        // R4: writes to code 0 change nothing
        wr(2'd0, 8'h3C);
        peek(2'd1, v); chk("R4 out kept", v, 8'hA5);
        peek(2'd2, v); chk("R4 pol kept", v, 8'hF0);
        peek(2'd3, v); chk("R4 cfg kept", v, 8'h00);
        peek(2'd0, v); chk("R4 inp kept", v, 8'h00);

        // R2: same-cycle select to register mapping
        wr(2'd2, 8'h69);
        reg_sel = 2'd1; #1; chk("R2 sel1", rd_data, 8'hA5);
        reg_sel = 2'd2; #1; chk("R2 sel2", rd_data, 8'h69);
        reg_sel = 2'd3; #1; chk("R2 sel3", rd_data, 8'h00);

        // R3/R7: sweep of direction values against output values
        for (int c = 0; c < 256; c++) begin
            logic [7:0] o;
            o = 8'(c * 29 + 3);
            wr(2'd1, o);
            wr(2'd3, 8'(c));
            @(negedge clk);
            chk("R3 oe sweep", pad_oe, exp_oe(8'(c), o));
            chk("R7 drv sweep", pad_drv, exp_drv(8'(c), o));
        end
        // R7: line 0 output with both values
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h01);
        @(negedge clk);
        chk("R7 od high floats", pad_oe & 8'h01, 8'h00);
        wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R7 od low sinks", pad_oe & 8'h01, 8'h01);

        // R6: output readback ignores pads; inputs do not drive
        wr(2'd3, 8'hFF);
        wr(2'd1, 8'hFF);
        pad_in = 8'h00;
        @(negedge clk);
        peek(2'd1, v); chk("R6 out readback", v, 8'hFF);
        chk("R6 inputs not driven", pad_drv | pad_oe, 8'h00);

        // R5: inversion sweep over all masks, mixed directions
        wr(2'd3, 8'h0F);
        for (int p = 0; p < 256; p++) begin
            logic [7:0] pins;
            pins = 8'(p * 37 + 11);
            wr(2'd2, 8'(p));
            pad_in = pins;
            capture();
            peek(2'd0, v); chk("R5 capture", v, pins ^ 8'(p));
        end
        // R5: hold until next strobe
        peek(2'd0, held);
        pad_in = ~pad_in;
        @(negedge clk);
        @(negedge clk);
        peek(2'd0, v); chk("R5 hold", v, held);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule